// File: doc/BRIEF.md
# Two-Lane Carryless Multiply-Sum Unit

This unit takes two 128-bit operands and treats each as a pair of 64-bit lanes. Lane i of the first operand is multiplied by lane i of the second operand as polynomials over GF(2). In this kind of product the partial products are combined with XOR, so no carries propagate. Each lane product is 128 bits wide. The two lane products are then XORed together into a single 128-bit result. This is the multiply-and-fold step used in polynomial hashing and CRC folding. The unit does no reduction modulo a polynomial.

The unit is iterative. A `start` pulse while the unit is idle captures both operands. The unit then handles one multiplier bit per cycle in both lanes at once. After 64 steps it registers the folded result and raises `done` for one cycle. `busy` stays high while a run is in progress. The result stays on the output until a later run completes.

Top module: `clmul_pair_sum`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `busy` and `done` are 0 and `result` is all zeros.
- R2: Operands are paired by lane. Lane 0 is bits 63:0 and lane 1 is bits 127:64, and lane i of `opa` is multiplied only by lane i of `opb`. If `opa` has only lane 0 nonzero and `opb` has only lane 1 nonzero, `result` is 0.
- R3: Each lane product starts at zero. For every bit j (0 to 63) that is set in the `opa` lane, the `opb` lane is zero-extended to 128 bits, shifted left by j, and XORed into that lane's product.
- R4: `result` is the bitwise XOR of the lane 0 and lane 1 products.
- R5: A start is accepted on the clock edge where `start` is high and `busy` is low. `busy` is high from the next cycle until the 64th edge after the accepted edge. At that 64th edge `busy` falls and `done` rises. `done` is high for exactly one cycle.
- R6: `start` is ignored while `busy` is high. The operands and the timing of the run in progress do not change.
- R7: `result` keeps its value from one completion until the next completion, including through the whole of a following run.
- R8: Bit 127 of each lane product, and so bit 127 of `result`, is always 0.
- R9: A start given in the cycle where `done` is high is accepted and begins a new run.
- R10: Operands are captured only when a start is accepted. Changes on `opa` and `opb` during a run have no effect on that run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a run; taken only while idle |
| opa | input | 128 | Multiplier operand, two 64-bit lanes |
| opb | input | 128 | Multiplicand operand, two 64-bit lanes |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when `result` is updated |
| result | output | 128 | XOR of the two lane carryless products |

## Verification
Two pairs of events can share a cycle. The first is a completion and a new start. The bench drives `start` in the same cycle that it first sees `done`, then checks that the second run gives its own product and takes the full 64 steps. The second is a running multiply and a fresh start with different operands. The bench pulses `start` in the middle of a run and changes the operand inputs, then checks that the result and the latency still match the first operands. Directed runs cover cross-lane isolation and all-ones operands. Random runs with a fixed seed cover the rest, all checked against a bit-serial reference function in the bench.

// File: rtl/clmul_pkg.sv
package clmul_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/clmul_ctrl.sv
module clmul_ctrl #(
  parameter int STEPS = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step,
  output logic last,
  output logic busy,
  output logic done
);
  import clmul_pkg::*;
  localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;

  run_state_e       state;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    busy = (state == ST_RUN);
    load = start && (state == ST_IDLE);
    step = (state == ST_RUN);
    last = (state == ST_RUN) && (cnt == CNT_W'(STEPS - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= last;
      if (load) begin
        state <= ST_RUN;
        cnt   <= '0;
      end else if (last) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else if (step) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R5
  finish_seq_chk: assert property (@(posedge clk) disable iff (rst) last |=> (done && !busy));
  // R6
  ignore_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !last && start) |=> (busy && cnt == $past(cnt) + CNT_W'(1)));
  // R9
  restart_chk: assert property (@(posedge clk) disable iff (rst) (done && start) |=> busy);
endmodule

// File: rtl/clmul_lane.sv
module clmul_lane #(
  parameter int LANE_W = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic                  step,
  input  logic [LANE_W-1:0]     a_dw,
  input  logic [LANE_W-1:0]     b_dw,
  output logic [2*LANE_W-1:0]   prod_nxt
);
  localparam int PROD_W = 2 * LANE_W;

  logic [LANE_W-1:0] mplier;
  logic [PROD_W-1:0] mcand;
  logic [PROD_W-1:0] acc;

  always_comb prod_nxt = acc ^ (mplier[0] ? mcand : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      mplier <= '0;
      mcand  <= '0;
      acc    <= '0;
    end else if (load) begin
      mplier <= a_dw;
      mcand  <= {{LANE_W{1'b0}}, b_dw};
      acc    <= '0;
    end else if (step) begin
      mplier <= mplier >> 1;
      mcand  <= mcand << 1;
      acc    <= prod_nxt;
    end
  end

  // R8
  lane_msb_chk: assert property (@(posedge clk) disable iff (rst) acc[PROD_W-1] == 1'b0);
  // R3
  lane_clear_chk: assert property (@(posedge clk) disable iff (rst) load |=> (acc == '0));
endmodule

// File: rtl/clmul_pair_sum.sv
module clmul_pair_sum #(
  parameter int LANE_W = 64,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [LANE_W*LANES-1:0]   opa,
  input  logic [LANE_W*LANES-1:0]   opb,
  output logic                      busy,
  output logic                      done,
  output logic [2*LANE_W-1:0]       result
);
  localparam int PROD_W = 2 * LANE_W;

  logic load, step, last;
  logic [PROD_W-1:0] lane_nxt [LANES];
  logic [PROD_W-1:0] folded;

  clmul_ctrl #(.STEPS(LANE_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .load(load), .step(step), .last(last),
    .busy(busy), .done(done)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    clmul_lane #(.LANE_W(LANE_W)) u_lane (
      .clk(clk), .rst(rst), .load(load), .step(step),
      .a_dw(opa[g*LANE_W +: LANE_W]),
      .b_dw(opb[g*LANE_W +: LANE_W]),
      .prod_nxt(lane_nxt[g])
    );
  end

  always_comb begin
    folded = '0;
    for (int i = 0; i < LANES; i++) folded = folded ^ lane_nxt[i];
  end

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else if (last) result <= folded;
  end

  // R7
  hold_result_chk: assert property (@(posedge clk) disable iff (rst) !done |-> $stable(result));
  // R8
  result_msb_chk: assert property (@(posedge clk) disable iff (rst) result[PROD_W-1] == 1'b0);
endmodule

// File: tb/clmul_pair_sum_test.sv
module clmul_pair_sum_test;
  localparam int LW = 64;
  localparam int NL = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [127:0] opa = '0, opb = '0;
  logic busy, done;
  logic [127:0] result;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  clmul_pair_sum #(.LANE_W(LW), .LANES(NL)) uut (
    .clk(clk), .rst(rst), .start(start), .opa(opa), .opb(opb),
    .busy(busy), .done(done), .result(result)
  );

  function automatic logic [127:0] ref_lane(input logic [63:0] a, input logic [63:0] b);
    logic [127:0] p = '0;
    for (int j = 0; j < 64; j++)
      if (a[j]) p = p ^ ({64'd0, b} << j);
    return p;
  endfunction

  function automatic logic [127:0] ref_sum(input logic [127:0] a, input logic [127:0] b);
    return ref_lane(a[63:0], b[63:0]) ^ ref_lane(a[127:64], b[127:64]);
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Raises start with operands at the current negedge; the next posedge accepts it.
  task automatic launch(input logic [127:0] a, input logic [127:0] b);
    start = 1'b1;
    opa = a;
    opb = b;
  endtask

  // Follows a run started by launch(). If a start lies at negedge 0, then done is
  // seen at negedge 65: 64 steps plus the edge that accepts the start.
  task automatic follow(input logic [127:0] exp, input bit inject, input bit hold_chk,
                        input logic [127:0] old, input bit chain, input logic [127:0] na,
                        input logic [127:0] nb);
    int cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) begin
        start = 1'b0;
        check(busy == 1'b1, "R5 busy after accept", {127'd0, busy}, 128'd1);
        opa = rnd128();  // R10: changes during a run must be ignored
        opb = rnd128();
      end
      if (inject && cyc == 10) begin
        start = 1'b1;
        opa = rnd128();
        opb = rnd128();
      end
      if (inject && cyc == 11) start = 1'b0;
      if (hold_chk && cyc == 30)
        check(result == old, "R7 result held during run", result, old);
      if (done || cyc > 80) break;
    end
    check(cyc == 65, "R5 latency", 128'(cyc), 128'd65);
    check(result == exp, inject ? "R6 start during run ignored" : "R3/R4 folded product", result, exp);
    check(result[127] == 1'b0, "R8 top bit zero", {127'd0, result[127]}, 128'd0);
    check(busy == 1'b0, "R5 idle at done", {127'd0, busy}, 128'd0);
    if (chain) begin
      launch(na, nb);  // R9: start in the done cycle
    end else begin
      @(negedge clk);
      check(done == 1'b0, "R5 done one cycle", {127'd0, done}, 128'd0);
      check(result == exp, "R7 result held idle", result, exp);
    end
  endtask

  initial begin
    logic [127:0] a, b, e, prev;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && result == '0, "R1 reset state", result, '0);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 0 && done == 0 && result == '0, "R1 after release", result, '0);

    // R2: cross-lane isolation
    a = {64'd0, 64'hFFFF_FFFF_FFFF_FFFF};
    b = {64'hFFFF_FFFF_FFFF_FFFF, 64'd0};
    launch(a, b);
    follow(128'd0, 0, 0, '0, 0, '0, '0);

    // R3: single lane, all ones, so result = 0x5555..55 below bit 127
    a = {64'd0, {64{1'b1}}};
    b = a;
    e = ref_sum(a, b);
    check(e == {1'b0, {63{2'b10}}, 1'b1}, "R3 reference sanity", e, {1'b0, {63{2'b10}}, 1'b1});
    prev = result;
    launch(a, b);
    follow(e, 0, 1, prev, 0, '0, '0);

    // R4: both lanes, all ones, so the two lane products cancel
    a = '1;
    b = '1;
    launch(a, b);
    follow('0, 0, 0, '0, 0, '0, '0);

    // R3: shift by 63 in lane 1
    a = {64'h8000_0000_0000_0000, 64'd0};
    b = {64'h8000_0000_0000_0001, 64'd0};
    launch(a, b);
    follow(ref_sum(a, b), 0, 0, '0, 0, '0, '0);

    // R6: start injected mid-run
    a = rnd128();
    b = rnd128();
    launch(a, b);
    follow(ref_sum(a, b), 1, 0, '0, 0, '0, '0);

    // R9: back-to-back chain
    a = rnd128();
    b = rnd128();
    launch(a, b);
    e = ref_sum(a, b);
    begin
      logic [127:0] a2, b2;
      a2 = rnd128();
      b2 = rnd128();
      follow(e, 0, 0, '0, 1, a2, b2);
      follow(ref_sum(a2, b2), 0, 1, e, 0, '0, '0);
    end

    // Random runs (R3, R4, R7, R10)
    for (int k = 0; k < 20; k++) begin
      a = rnd128();
      b = rnd128();
      prev = result;
      launch(a, b);
      follow(ref_sum(a, b), (k % 4) == 3, 1, prev, 0, '0, '0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule